// File: doc/BRIEF.md
# Configurable 16-bit Root Timer Channel

This block is one programmable timer channel. A 16-bit counter advances on a selectable time base: every system clock, once every eight system clocks, or once per rising edge of an external tick strobe such as a line or pixel clock. The external strobe may be asynchronous to the system clock. The counter is compared against a programmable target and against the 16-bit wrap. On either event it sets sticky status bits, can return the count to zero when the target is reached, and drives an interrupt request pulse. The interrupt can be one-shot or repeating.

Software uses the block through three registers on a small synchronous read/write port. Writing the mode register selects the behaviour, restarts the count from zero and rearms the one-shot interrupt. Reading the mode register returns the status bits and clears the two event flags. The count and target registers can be written at any time. Writing the target leaves the running count untouched.

Top module: `root_timer`

## Requirements
- R1: Register addresses are count = 0, mode = 1 and target = 2. A read issued with rd_en in one cycle presents its data on rdata from the next clock edge. After reset the count, mode and target all read 0 and irq is low.
- R2: With mode bits 0, 8 and 9 clear, the count advances by one on every system clock. From 0xFFFF it wraps to 0, and that wrap sets the overflow flag in mode bit 12.
- R3: With mode bit 3 set, a tick that would take the count to the target value loads 0 instead and raises the target event. With a target of 0 the count stays at 0 and the target event fires on every tick.
- R4: With mode bit 3 clear, the count passes the target and keeps counting to the wrap. The tick that takes the count to the target raises the target event.
- R5: Mode bit 4 enables the interrupt on the target event and mode bit 5 enables it on the wrap event. irq is a one-cycle high pulse that appears at the same clock edge as the count update that caused it. With both bits clear, irq stays low.
- R6: Without mode bit 6, only the first qualifying event after a mode write pulses irq. With bit 6 set, every qualifying event pulses irq. A mode write rearms the one-shot state.
- R7: Mode bit 11 is a sticky target flag, bit 12 is a sticky wrap flag, and bit 10 is set by either event. A mode read returns the current value and then clears bits 11 and 12, leaving every other bit unchanged. An event in the same cycle as the read still sets its flags.
- R8: A mode write stores written bits 9..0, clears bits 15..10, sets the count to 0 and restarts the divide-by-eight prescaler.
- R9: Mode bit 9 makes the count advance once every 8 system clocks, first at the 8th clock after the mode write. Otherwise mode bit 8 makes it advance once per rising edge of ext_tick. Bit 9 takes priority over bit 8.
- R10: Mode bit 0 stops the counter. It does not advance while the bit is set, although count writes still load it.
- R11: A target write leaves the count value unchanged. The next event comparison uses the new target.
- R12: A count write loads only the low 16 bits of wdata into the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 count, 1 mode, 2 target |
| wdata | input | 32 | Write data |
| ext_tick | input | 1 | External tick strobe, asynchronous, rising edge counts |
| rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request pulse |

## Verification
The assertions take for granted that at most one register write occurs per cycle and that ext_tick stays high and low for at least two system clocks, so that the synchroniser sees every edge. The stimulus drives ext_tick as pulses three cycles high and three cycles low. It changes the strobes only just after a clock edge, and it always issues a write as a single one-cycle strobe. Every target and count value the stimulus uses is loaded while the effect of that load can be predicted from the clock count since the last write.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
  localparam int MODE_W = 16;

  typedef enum logic [1:0] {
    RA_COUNT  = 2'd0,
    RA_MODE   = 2'd1,
    RA_TARGET = 2'd2
  } reg_addr_e;

  // mode register bit positions
  localparam int MB_STOP    = 0;
  localparam int MB_RST_TGT = 3;
  localparam int MB_IRQ_TGT = 4;
  localparam int MB_IRQ_OVF = 5;
  localparam int MB_REPEAT  = 6;
  localparam int MB_EXT     = 8;
  localparam int MB_DIV     = 9;
  localparam int MB_EVENT   = 10;
  localparam int MB_HIT_TGT = 11;
  localparam int MB_HIT_OVF = 12;
  localparam int MB_CTRL_HI = 9;
endpackage

// File: rtl/rtmr_tick_sel.sv
module rtmr_tick_sel #(
  parameter int DIV  = 8,
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic stop,
  input  logic div_sel,
  input  logic ext_sel,
  input  logic ext_tick,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic            ext_edge;
  logic            div_tick;

  // prescaler for the divided time base
  generate
    if (DIV > 1) begin : g_div
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst || restart)
          pre_q <= '0;
        else if (pre_q == PW'(DIV - 1))
          pre_q <= '0;
        else
          pre_q <= pre_q + 1'b1;
      end
      assign div_tick = (pre_q == PW'(DIV - 1));
    end else begin : g_nodiv
      assign div_tick = 1'b1;
    end
  endgenerate

  // synchroniser chain for the external strobe
  genvar gi;
  generate
    for (gi = 0; gi < SYNC; gi++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst)
          sync_q[gi] <= 1'b0;
        else if (gi == 0)
          sync_q[gi] <= ext_tick;
        else
          sync_q[gi] <= sync_q[(gi > 0) ? gi - 1 : 0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      prev_q <= 1'b0;
    else
      prev_q <= sync_q[SYNC-1];
  end

  assign ext_edge = sync_q[SYNC-1] & ~prev_q;

  always_comb begin
    if (stop)
      tick = 1'b0;
    else if (div_sel)
      tick = div_tick;
    else if (ext_sel)
      tick = ext_edge;
    else
      tick = 1'b1;
  end

  // R9: divided ticks never come back to back
  assert_div_gap_R9: assert property (@(posedge clk) disable iff (rst)
    (DIV > 1 && div_sel && !stop && tick && !restart) |=> !div_tick);

  // R9: one external edge yields a single tick
  assert_ext_single_R9: assert property (@(posedge clk) disable iff (rst)
    ext_edge |=> !ext_edge);
endmodule

// File: rtl/rtmr_counter.sv
module rtmr_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          clear,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          rst_on_tgt,
  input  logic [CW-1:0] target,
  output logic [CW-1:0] cnt,
  output logic          ev_tgt,
  output logic          ev_ovf
);
  logic [CW-1:0] nxt;
  logic          at_top;
  logic          tgt_match;
  logic          step_ok;
  logic          snap;

  assign nxt       = cnt + 1'b1;
  assign at_top    = (cnt == {CW{1'b1}});
  assign tgt_match = (nxt == target) || (rst_on_tgt && (target == '0));
  assign step_ok   = tick && !clear && !load;
  assign snap      = rst_on_tgt && tgt_match;

  assign ev_tgt = step_ok && tgt_match;
  assign ev_ovf = step_ok && at_top && !snap;

  always_ff @(posedge clk) begin
    if (rst || clear)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (tick)
      cnt <= snap ? '0 : nxt;
  end

  // R2: plain advance by one
  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (step_ok && !snap) |=> (cnt == $past(cnt) + 1'b1));

  // R3: target reached with return-to-zero lands on zero
  assert_snap_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (ev_tgt && rst_on_tgt) |=> (cnt == '0));

  // R2: wrap event only from the top value, landing on zero
  assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    ev_ovf |=> (cnt == '0 && $past(cnt) == {CW{1'b1}}));
endmodule

// File: rtl/rtmr_irq.sv
module rtmr_irq (
  input  logic clk,
  input  logic rst,
  input  logic rearm,
  input  logic repeat_en,
  input  logic en_tgt,
  input  logic en_ovf,
  input  logic ev_tgt,
  input  logic ev_ovf,
  output logic irq
);
  logic fired_q;
  logic want;
  logic fire;

  assign want = (en_tgt && ev_tgt) || (en_ovf && ev_ovf);
  assign fire = want && (repeat_en || !fired_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      fired_q <= 1'b0;
    end else begin
      irq <= fire;
      if (rearm)
        fired_q <= 1'b0;
      else if (fire)
        fired_q <= 1'b1;
    end
  end

  // R6: once fired in one-shot mode, no further pulse until rearmed
  assert_oneshot_R6: assert property (@(posedge clk) disable iff (rst)
    (fired_q && !repeat_en && !rearm) |=> !irq);

  // R5: a pulse always follows an enabled event
  assert_cause_R5: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(want));
endmodule

// File: rtl/root_timer.sv
module root_timer #(
  parameter int CW   = 16,
  parameter int DW   = 32,
  parameter int DIV  = 8,
  parameter int SYNC = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [1:0]          addr,
  input  logic [DW-1:0]       wdata,
  input  logic                ext_tick,
  output logic [rtmr_pkg::MODE_W-1:0] rdata,
  output logic                irq
);
  import rtmr_pkg::*;

  localparam int RW = MODE_W;

  logic [MODE_W-1:0] mode_q;
  logic [CW-1:0]     target_q;
  logic [CW-1:0]     cnt;
  logic              tick;
  logic              ev_tgt;
  logic              ev_ovf;
  logic              wr_cnt, wr_mode, wr_tgt, rd_mode;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[DW-1:CW];

  assign wr_cnt  = wr_en && (addr == RA_COUNT);
  assign wr_mode = wr_en && (addr == RA_MODE);
  assign wr_tgt  = wr_en && (addr == RA_TARGET);
  assign rd_mode = rd_en && (addr == RA_MODE);

  rtmr_tick_sel #(.DIV(DIV), .SYNC(SYNC)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .restart  (wr_mode),
    .stop     (mode_q[MB_STOP]),
    .div_sel  (mode_q[MB_DIV]),
    .ext_sel  (mode_q[MB_EXT]),
    .ext_tick (ext_tick),
    .tick     (tick)
  );

  rtmr_counter #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .clear      (wr_mode),
    .load       (wr_cnt),
    .load_val   (wdata[CW-1:0]),
    .rst_on_tgt (mode_q[MB_RST_TGT]),
    .target     (target_q),
    .cnt        (cnt),
    .ev_tgt     (ev_tgt),
    .ev_ovf     (ev_ovf)
  );

  rtmr_irq u_irq (
    .clk       (clk),
    .rst       (rst),
    .rearm     (wr_mode),
    .repeat_en (mode_q[MB_REPEAT]),
    .en_tgt    (mode_q[MB_IRQ_TGT]),
    .en_ovf    (mode_q[MB_IRQ_OVF]),
    .ev_tgt    (ev_tgt),
    .ev_ovf    (ev_ovf),
    .irq       (irq)
  );

  // mode register: control bits from writes, status bits from events
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else if (wr_mode) begin
      mode_q <= {{(MODE_W-MB_CTRL_HI-1){1'b0}}, wdata[MB_CTRL_HI:0]};
    end else begin
      if (rd_mode) begin
        mode_q[MB_HIT_TGT] <= 1'b0;
        mode_q[MB_HIT_OVF] <= 1'b0;
      end
      if (ev_tgt) begin
        mode_q[MB_HIT_TGT] <= 1'b1;
        mode_q[MB_EVENT]   <= 1'b1;
      end
      if (ev_ovf) begin
        mode_q[MB_HIT_OVF] <= 1'b1;
        mode_q[MB_EVENT]   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      target_q <= '0;
    else if (wr_tgt)
      target_q <= wdata[CW-1:0];
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        RA_COUNT:  rdata <= RW'(cnt);
        RA_MODE:   rdata <= mode_q;
        RA_TARGET: rdata <= RW'(target_q);
        default:   rdata <= '0;
      endcase
    end
  end

  // R8: a mode write restarts the count and drops status bits
  assert_modewr_R8: assert property (@(posedge clk) disable iff (rst)
    wr_mode |=> (cnt == '0 && mode_q[MODE_W-1:MB_EVENT] == '0));

  // R12: count write takes the low bits of the data word
  assert_ldcnt_R12: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> (cnt == $past(wdata[CW-1:0])));

  // R7: every pulse is accompanied by the any-event status bit
  assert_irq_flag_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> mode_q[MB_EVENT]);

  // R10: a stopped counter holds its value
  assert_stop_R10: assert property (@(posedge clk) disable iff (rst)
    (mode_q[MB_STOP] && !wr_cnt && !wr_mode) |=> (cnt == $past(cnt)));

  // R11: a target write alone never disturbs a stopped count
  assert_tgtwr_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_tgt && mode_q[MB_STOP]) |=> (cnt == $past(cnt)));

  // R7: a mode read clears both flags unless a new event sets them
  assert_rdclr_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_mode && !wr_mode && !ev_tgt && !ev_ovf) |=>
      (!mode_q[MB_HIT_TGT] && !mode_q[MB_HIT_OVF]));
endmodule

// File: tb/sim_root_timer.sv
module sim_root_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic        ext_tick = 1'b0;
  logic [15:0] rdata;
  logic        irq;

  localparam int M_STOP = 1, M_ROT = 8, M_ITGT = 16, M_IOVF = 32, M_REP = 64;
  localparam int M_EXT = 256, M_DIV = 512;
  localparam logic [1:0] A_CNT = 2'd0, A_MODE = 2'd1, A_TGT = 2'd2;

  root_timer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .ext_tick(ext_tick), .rdata(rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, output int t);
    addr = a; wdata = d; wr_en = 1'b1;
    step();
    t = cyc;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v, output int t);
    addr = a; rd_en = 1'b1;
    step();
    t = cyc;
    v = int'(rdata);
    rd_en = 1'b0;
  endtask

  task automatic watch(input int n, output int pulses, output int first);
    pulses = 0; first = -1;
    repeat (n) begin
      step();
      if (irq) begin
        pulses++;
        if (first < 0) first = cyc;
      end
    end
  endtask

  task automatic ext_pulse();
    ext_tick = 1'b1;
    repeat (3) step();
    ext_tick = 1'b0;
    repeat (3) step();
  endtask

  initial begin
    #(2_000_000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int t, w, r, v, p, f, tk;
    repeat (4) step();
    rst = 1'b0;

    // R1: reset values
    chk("R1 irq", int'(irq), 0);
    rd(A_CNT, v, t);  chk("R1 count", v, 0);
    rd(A_MODE, v, t); chk("R1 mode", v, 0);
    rd(A_TGT, v, t);  chk("R1 target", v, 0);

    // R12 and R10: stopped counter keeps a truncated load
    wr(A_MODE, M_STOP, t);
    wr(A_CNT, 32'h0001_2345, t);
    repeat (20) step();
    rd(A_CNT, v, t); chk("R12 low bits / R10 stop", v, 16'h2345);

    // R2: wrap and overflow flag
    wr(A_MODE, 0, t);
    wr(A_CNT, 32'hFFFC, w);
    repeat (10) step();
    rd(A_CNT, v, r); chk("R2 count", v, (16'hFFFC + r - w - 1) & 16'hFFFF);
    rd(A_MODE, v, t); chk("R2 wrap flags", v, 16'h1C00);
    rd(A_MODE, v, t); chk("R7 flags cleared", v, 16'h0400);

    // R3: sweep of targets with return to zero, repeating irq
    for (int tg = 0; tg < 8; tg++) begin
      wr(A_TGT, tg, t);
      wr(A_MODE, M_ROT | M_ITGT | M_REP, w);
      watch(48, p, f);
      chk($sformatf("R3 pulses tgt=%0d", tg), p, (tg == 0) ? 48 : 48 / tg);
      rd(A_CNT, v, r);
      chk($sformatf("R3 count tgt=%0d", tg), v, (tg == 0) ? 0 : (r - w - 1) % tg);
    end

    // R6: one-shot and rearm
    wr(A_TGT, 3, t);
    wr(A_MODE, M_ROT | M_ITGT, w);
    watch(30, p, f);
    chk("R6 one-shot pulses", p, 1);
    chk("R6 one-shot edge", f, w + 3);
    wr(A_MODE, M_ROT | M_ITGT, w);
    watch(30, p, f);
    chk("R6 rearm pulses", p, 1);

    // R4: count passes the target
    wr(A_TGT, 5, t);
    wr(A_MODE, M_ITGT | M_REP, w);
    watch(20, p, f);
    chk("R4 pulses", p, 1);
    chk("R4 edge", f, w + 5);
    rd(A_CNT, v, r); chk("R4 count beyond target", v, r - w - 1);

    // R5: overflow interrupt only
    wr(A_TGT, 3, t);
    wr(A_MODE, M_IOVF | M_REP, t);
    wr(A_CNT, 32'hFFFE, w);
    watch(10, p, f);
    chk("R5 ovf pulses", p, 1);
    chk("R5 ovf edge", f, w + 2);

    // R7: both flags then read clear, control bits kept
    rd(A_MODE, v, t); chk("R7 mode flags", v, 16'h1C60);
    rd(A_MODE, v, t); chk("R7 mode after clear", v, 16'h0460);

    // R8: mode write drops status bits and clears count
    wr(A_MODE, 16'h1C00 | M_STOP, t);
    rd(A_MODE, v, t); chk("R8 mode stored", v, 1);
    rd(A_CNT, v, t);  chk("R8 count zero", v, 0);

    // R5: no enables, no pulses
    wr(A_TGT, 2, t);
    wr(A_MODE, M_ROT, t);
    watch(20, p, f);
    chk("R5 disabled pulses", p, 0);

    // R9: divide by eight
    wr(A_TGT, 3, t);
    wr(A_MODE, M_DIV | M_ROT | M_ITGT | M_REP, w);
    watch(64, p, f);
    chk("R9 div pulses", p, 2);
    chk("R9 div first edge", f, w + 24);
    rd(A_CNT, v, r);
    tk = (r - 1 - w) / 8;
    chk("R9 div count", v, tk % 3);

    // R9: external tick
    wr(A_TGT, 0, t);
    wr(A_MODE, M_EXT, w);
    repeat (5) ext_pulse();
    repeat (5) step();
    rd(A_CNT, v, r); chk("R9 ext count", v, 5);

    // R9: divider has priority over external tick
    wr(A_MODE, M_EXT | M_DIV, w);
    repeat (6) ext_pulse();
    rd(A_CNT, v, r); chk("R9 priority count", v, (r - 1 - w) / 8);

    // R11: target write keeps count and applies to next compare
    wr(A_TGT, 100, t);
    wr(A_MODE, M_ROT | M_ITGT | M_REP, t);
    wr(A_CNT, 10, w);
    wr(A_TGT, 50, t);
    rd(A_CNT, v, r); chk("R11 count kept", v, 10 + r - w - 1);
    watch(60, p, f);
    chk("R11 new target edge", f, w + 40);
    chk("R11 pulses", p, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule